// File: doc/BRIEF.md
# Accelerometer Register Target on a Two-Wire Bus

This block is the two-wire (I2C) target front end of a sensor interface. It watches the SCL and SDA lines, oversampled on the system clock, detects start, repeated start and stop conditions, and answers a 7-bit device address. The upper six bits of that address are fixed and the lowest bit follows a strap pin. Once addressed, the block moves bytes between the bus and an external byte-wide register file. It does this through a register pointer that the master loads and that steps forward after every byte.

Writes load the pointer from the first byte and then store each further byte at the pointer. Reads are combined transfers: a write carries the pointer, then a repeated start switches direction and bytes stream out until the master NACKs. When the external hold-enable bit is set and the next byte to send is the high byte of an axis sample, the block requests a conversion. It then keeps SCL low until the conversion reports done, and only then drives the fresh data. Both bus lines are open drain and appear as active-high pull-low enables.

Top module: `accel_i2c_target`

## Requirements
- R1: The block answers only the device address {6'b001100, addr_pin}. Any other address is not acknowledged, and SDA is not driven again until the next start condition.
- R2: Every byte the block accepts is acknowledged by pulling SDA low across the whole high phase of the ninth clock. SDA is only changed while SCL is low, except when the bus is released at a start or stop.
- R3: In a write transfer, the first byte after the address loads the pointer. Each later byte produces exactly one single-cycle write strobe at the current pointer, and the pointer then advances.
- R4: A pointer byte whose bit 7 is 1 is not acknowledged. The block then drops the transfer and issues no write strobe.
- R5: The pointer steps over the unused location 0x07 and wraps from 0x0E back to 0x00. The register map is 0x00–0x06 and 0x08–0x0E.
- R6: In a read transfer, bytes are sent MSB first from the pointer, and the pointer advances after each byte. A master ACK fetches the next byte. A master NACK ends the transfer with SDA released.
- R7: With hold_en set, when the byte about to be sent sits at 0x00, 0x02 or 0x04, a single-cycle conv_req is raised and SCL is held low until conv_done. With hold_en clear, SCL is never held and conv_req stays low.
- R8: A stop releases both lines and returns the block to idle. A repeated start begins a new address phase and keeps the pointer.
- R9: After reset, both line enables and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pin | input | 1 | Strap that sets the lowest device address bit |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| hold_en | input | 1 | Clock-hold bit from the control register |
| conv_done | input | 1 | Conversion finished pulse |
| conv_req | output | 1 | Conversion request pulse |
| rd_addr | output | 4 | Register pointer presented to the register file |
| rd_data | input | 8 | Register file read data at rd_addr |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 4 | Register write address |
| wr_data | output | 8 | Register write data |

## Verification
Two things land on one clock edge after each received data byte: the write strobe and the pointer advance. The strobe must carry the old pointer while the pointer moves to the next legal location. Multi-byte writes that start at 0x05 and at 0x0E provoke this across the hole and the wrap. The result is judged by reading the register file at 0x06, 0x07, 0x08 and 0x00 against a bench model. A second coincidence is the release of a stretched SCL and the first data bit being put on SDA. Hold-enabled reads with a random conversion delay provoke it, and the bench compares the returned byte and the measured hold length against its model.

// File: rtl/accel_i2c_pkg.sv
package accel_i2c_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_LOAD,
    ST_WAIT,
    ST_TX,
    ST_MACK
  } tgt_state_t;

  localparam logic [5:0] DEV_ID_HI = 6'b001100;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], raw[g]};
      end
      assign synced[g] = pipe[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= synced;
  end

  assign scl_s    = synced[0];
  assign sda_s    = synced[1];
  assign scl_rise = synced[0] & ~prev[0];
  assign scl_fall = ~synced[0] & prev[0];
  assign start_ev = prev[0] & synced[0] & prev[1] & ~synced[1];
  assign stop_ev  = prev[0] & synced[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/reg_ptr.sv
module reg_ptr #(
  parameter int PTR_W     = 4,
  parameter int LAST_ADDR = 14,
  parameter int HOLE_ADDR = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST_ADDR);
  localparam logic [PTR_W-1:0] HOLE_P = PTR_W'(HOLE_ADDR);
  localparam logic [PTR_W-1:0] ONE_P  = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO_P  = PTR_W'(2);

  logic [PTR_W-1:0] nxt;

  always_comb begin
    if (ptr >= LAST_P)              nxt = '0;
    else if (ptr + ONE_P == HOLE_P) nxt = ptr + TWO_P;
    else                            nxt = ptr + ONE_P;
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= nxt;
  end

  assert_skip_hole_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (ptr != HOLE_P));
  assert_in_map_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (ptr <= LAST_P));
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import accel_i2c_pkg::*;
#(
  parameter int PTR_W       = 4,
  parameter int SAMPLE_LAST = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             addr_pin,
  input  logic             hold_en,
  input  logic             conv_done,
  input  logic [PTR_W-1:0] ptr,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             scl_oe,
  output logic             conv_req,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             ptr_load,
  output logic [PTR_W-1:0] ptr_load_val,
  output logic             ptr_inc
);
  localparam logic [PTR_W-1:0] SAMPLE_P = PTR_W'(SAMPLE_LAST);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);

  tgt_state_t       state;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] bitcnt;
  logic             rw;
  logic             first;
  logic             mack;
  logic             sample_hi;

  assign sample_hi = (ptr <= SAMPLE_P) && !ptr[0];

  always_ff @(posedge clk) begin
    conv_req <= 1'b0;
    wr_en    <= 1'b0;
    ptr_load <= 1'b0;
    ptr_inc  <= 1'b0;
    if (rst) begin
      state        <= ST_IDLE;
      shreg        <= '0;
      bitcnt       <= '0;
      rw           <= 1'b0;
      first        <= 1'b0;
      mack         <= 1'b0;
      sda_oe       <= 1'b0;
      scl_oe       <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      ptr_load_val <= '0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == FULL_BYTE) begin
            if (shreg[7:1] == {DEV_ID_HI, addr_pin}) begin
              sda_oe <= 1'b1;
              rw     <= shreg[0];
              state  <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            first  <= 1'b1;
            state  <= rw ? ST_LOAD : ST_RX;
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == FULL_BYTE) begin
            if (first) begin
              if (shreg[7]) begin
                state <= ST_IDLE;
              end else begin
                ptr_load     <= 1'b1;
                ptr_load_val <= shreg[PTR_W-1:0];
                first        <= 1'b0;
                sda_oe       <= 1'b1;
                state        <= ST_RX_ACK;
              end
            end else begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= shreg;
              ptr_inc <= 1'b1;
              sda_oe  <= 1'b1;
              state   <= ST_RX_ACK;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_RX;
          end
        end
        ST_LOAD: begin
          bitcnt <= '0;
          if (hold_en && sample_hi) begin
            scl_oe   <= 1'b1;
            conv_req <= 1'b1;
            state    <= ST_WAIT;
          end else begin
            shreg  <= rd_data;
            sda_oe <= ~rd_data[7];
            state  <= ST_TX;
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            scl_oe <= 1'b0;
            shreg  <= rd_data;
            sda_oe <= ~rd_data[7];
            state  <= ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe  <= 1'b0;
              ptr_inc <= 1'b1;
              state   <= ST_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) state <= mack ? ST_LOAD : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sda_low_phase_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start_ev || stop_ev)) |-> !$past(scl_s));
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (state == ST_IDLE && !sda_oe && !scl_oe));
  assert_wr_single_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  assert_conv_single_R7: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> (!conv_req && scl_oe));
  assert_stretch_gated_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> $past(hold_en));
endmodule

// File: rtl/accel_i2c_target.sv
module accel_i2c_target #(
  parameter int PTR_W       = 4,
  parameter int LAST_ADDR   = 14,
  parameter int HOLE_ADDR   = 7,
  parameter int SAMPLE_LAST = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_pin,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             hold_en,
  input  logic             conv_done,
  output logic             conv_req,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic             ptr_load, ptr_inc;
  logic [PTR_W-1:0] ptr_load_val, ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  reg_ptr #(.PTR_W(PTR_W), .LAST_ADDR(LAST_ADDR), .HOLE_ADDR(HOLE_ADDR)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_load_val),
    .inc(ptr_inc), .ptr(ptr)
  );

  i2c_target_fsm #(.PTR_W(PTR_W), .SAMPLE_LAST(SAMPLE_LAST)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .addr_pin(addr_pin),
    .hold_en(hold_en), .conv_done(conv_done), .ptr(ptr), .rd_data(rd_data),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .conv_req(conv_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc)
  );

  assign rd_addr = ptr;
endmodule

// File: tb/accel_i2c_target_test.sv
`timescale 1ns/1ps
module accel_i2c_target_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m_low = 1'b0, sda_m_low = 1'b0;
  logic addr_pin = 1'b0, hold_en = 1'b0, conv_done = 1'b0;
  logic scl_oe, sda_oe, conv_req, wr_en;
  logic [3:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic scl_bus, sda_bus;

  logic [7:0] regfile [16];
  logic [7:0] expv [16];
  int n_checks = 0, n_bad = 0;
  int wr_count = 0, conv_count = 0, stretch_cyc = 0, sda_drv = 0;
  int conv_delay = 40, conv_cnt = 0;

  always #2.5 clk = ~clk;

  assign scl_bus = !(scl_m_low || scl_oe);
  assign sda_bus = !(sda_m_low || sda_oe);
  assign rd_data = regfile[rd_addr];

  accel_i2c_target uut (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus), .addr_pin(addr_pin),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .hold_en(hold_en), .conv_done(conv_done),
    .conv_req(conv_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (wr_en) begin regfile[wr_addr] <= wr_data; wr_count <= wr_count + 1; end
    if (scl_oe) stretch_cyc <= stretch_cyc + 1;
    if (sda_oe) sda_drv <= sda_drv + 1;
    conv_done <= 1'b0;
    if (conv_req) begin conv_cnt <= conv_delay; conv_count <= conv_count + 1; end
    else if (conv_cnt != 0) begin
      conv_cnt <= conv_cnt - 1;
      if (conv_cnt == 1) conv_done <= 1'b1;
    end
  end

  function automatic int next_ptr(input int p);
    if (p >= 14) return 0;
    if (p + 1 == 7) return 8;
    return p + 1;
  endfunction

  function automatic int legal_addr(input int k);
    return (k < 7) ? k : k + 1;
  endfunction

  function automatic bit sample_hi(input int p);
    return (p <= 5) && (p % 2 == 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m_low = 1'b0;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m_low = 1'b1; wait_q();
    scl_m_low = 1'b1; wait_q();
  endtask

  task automatic bus_rstart();
    sda_m_low = 1'b0; wait_q();
    scl_up(); wait_q();
    sda_m_low = 1'b1; wait_q();
    scl_m_low = 1'b1; wait_q();
  endtask

  task automatic bus_stop();
    sda_m_low = 1'b1; wait_q();
    scl_up(); wait_q();
    sda_m_low = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m_low = !b[i]; wait_q();
      scl_up(); wait_q(); wait_q();
      scl_m_low = 1'b1;
    end
    sda_m_low = 1'b0; wait_q();
    scl_up(); wait_q();
    ack = !sda_bus;
    wait_q();
    scl_m_low = 1'b1; wait_q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      scl_up(); wait_q();
      b[i] = sda_bus;
      wait_q();
      scl_m_low = 1'b1;
    end
    sda_m_low = give_ack; wait_q();
    scl_up(); wait_q(); wait_q();
    scl_m_low = 1'b1; wait_q();
    sda_m_low = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] dev, input int ra, input int n);
    bit ack;
    int p;
    logic [7:0] d;
    bus_start();
    send_byte({dev, 1'b0}, ack); check("R1 write address ack", ack, 1);
    send_byte(8'(ra), ack);      check("R2 pointer byte ack", ack, 1);
    p = ra;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack); check("R2 data ack", ack, 1);
      expv[p] = d;
      p = next_ptr(p);
    end
    bus_stop();
    repeat (4) @(negedge clk);
    check("R8 lines released after stop", {30'd0, scl_oe, sda_oe}, 0);
    for (int a = 0; a < 16; a++)
      if (a != 15) check("R3/R5 register contents", regfile[a], expv[a]);
  endtask

  task automatic do_read(input int ra, input int n, input bit hold);
    bit ack;
    int p, conv0, exp_conv;
    logic [7:0] d;
    hold_en = hold;
    conv0 = conv_count;
    exp_conv = 0;
    bus_start();
    send_byte({6'b001100, addr_pin, 1'b0}, ack); check("R1 address ack", ack, 1);
    send_byte(8'(ra), ack);                      check("R2 pointer ack", ack, 1);
    bus_rstart();
    send_byte({6'b001100, addr_pin, 1'b1}, ack); check("R8 read after repeated start ack", ack, 1);
    p = ra;
    for (int k = 0; k < n; k++) begin
      if (hold && sample_hi(p)) exp_conv++;
      recv_byte(k != n - 1, d);
      check("R6 read data", d, expv[p]);
      p = next_ptr(p);
    end
    check("R6 SDA released after master NACK", sda_oe, 0);
    bus_stop();
    repeat (4) @(negedge clk);
    check("R7 conversion request count", conv_count - conv0, exp_conv);
    hold_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    bit ack;
    int s0, w0, ra, n;
    void'($urandom(32'd20240611));
    for (int a = 0; a < 16; a++) begin
      regfile[a] = 8'(a * 37 + 5);
      expv[a] = 8'(a * 37 + 5);
    end
    repeat (5) @(negedge clk);
    check("R9 reset sda_oe", sda_oe, 0);
    check("R9 reset scl_oe", scl_oe, 0);
    check("R9 reset strobes", {30'd0, wr_en, conv_req}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R3 plain multi-byte write
    do_write(7'h18, 9, 3);
    // R5 write across the hole at 0x07
    do_write(7'h18, 5, 3);
    check("R5 hole untouched", regfile[7], 8'(7 * 37 + 5));
    // R5 wrap 0x0E -> 0x00
    do_write(7'h18, 14, 2);

    // R6 read across wrap, no hold
    s0 = stretch_cyc;
    do_read(12, 4, 1'b0);
    do_read(0, 2, 1'b0);
    check("R7 no stretch when hold clear", stretch_cyc - s0, 0);

    // R7 stretched read of axis high byte
    conv_delay = 90;
    s0 = stretch_cyc;
    do_read(0, 2, 1'b1);
    check("R7 stretch at least conversion time", int'((stretch_cyc - s0) >= 90), 1);

    // R1 address mismatch
    w0 = sda_drv;
    bus_start();
    send_byte(8'h34, ack); check("R1 mismatch NACK", ack, 0);
    send_byte(8'h00, ack); check("R1 no ack after mismatch", ack, 0);
    bus_stop();
    check("R1 SDA never driven after mismatch", sda_drv - w0, 0);

    // R1 strap bit
    addr_pin = 1'b1;
    bus_start();
    send_byte(8'h30, ack); check("R1 old address rejected with strap high", ack, 0);
    bus_stop();
    do_write(7'h19, 2, 1);
    do_read(2, 2, 1'b0);
    addr_pin = 1'b0;

    // R4 pointer byte with bit 7 set
    w0 = wr_count;
    bus_start();
    send_byte(8'h30, ack); check("R4 address ack", ack, 1);
    send_byte(8'h85, ack); check("R4 pointer MSB set NACK", ack, 0);
    send_byte(8'hA5, ack); check("R4 data after bad pointer NACK", ack, 0);
    bus_stop();
    check("R4 no write strobe", wr_count - w0, 0);
    check("R4 location 5 unchanged", regfile[5], expv[5]);

    // R8 stop right after pointer byte
    bus_start();
    send_byte(8'h30, ack);
    send_byte(8'h0B, ack);
    bus_stop();
    repeat (4) @(negedge clk);
    check("R8 idle after early stop", {30'd0, scl_oe, sda_oe}, 0);
    do_read(11, 1, 1'b0);

    // random mix
    for (int t = 0; t < 14; t++) begin
      ra = legal_addr($urandom % 14);
      n  = 1 + ($urandom % 4);
      conv_delay = 20 + ($urandom % 100);
      if ($urandom % 2) do_write(7'h18, ra, n);
      else              do_read(ra, n, 1'($urandom % 2));
    end

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule